// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one 16-bit timer channel. A counter advances by one for each enable pulse. Four general registers, numbered 0 to 3, sit beside it. Each general register works in one of two modes:

- Compare mode: the register raises a one-cycle match pulse and sets its status flag when the counter counts up to its value.
- Capture mode: an external strobe copies the counter into the register and sets its flag.

Registers 2 and 3 have a further option. They can act as buffers for registers 0 and 1 instead of working on their own. In compare mode the buffer reloads its partner on every match. In capture mode the buffer keeps the value the partner held before the capture.

Software reaches the channel over a simple word-wide register bus. The bus also reports accesses that use the wrong size. A status flag is only cleared by a zero write that follows a read of that flag as one. This stops a clear from wiping out an event that software has not seen yet.

Top module: `cc_timer_chan`

## Requirements
- R1: Bus map: address 0 is the counter, addresses 1 to 4 are general registers 0 to 3, address 5 is status (bit i is the flag of register i), and address 6 is mode. In the mode register, bit i = 1 puts register i in capture mode, bit 4 = 1 makes register 2 the buffer of register 0, and bit 5 = 1 makes register 3 the buffer of register 1. After reset the counter, status and mode read as 0 and every general register reads 0xFFFF.
- R2: Each cycle with `cnt_en` high adds one to the counter, and 0xFFFF wraps to 0x0000.
- R3: A bus write to the counter takes priority over counting. `standby_req` forces the counter to 0 at the next edge, above both the bus write and counting.
- R4: A read or write with `bus_size16` low to addresses 0 to 4 raises `bus_err` in that same cycle. Such a write changes nothing, and such a read returns 0.
- R5: In compare mode, `match_pulse[i]` is high for the one cycle that follows a counting edge that brought the counter to the value of register i. Flag i sets at the end of that cycle.
- R6: In capture mode, a cycle with `cap_strobe[i]` high loads register i with the counter value of that cycle and sets flag i. In compare mode the strobe changes neither the register nor the flag.
- R7: A status write clears flag i only when data bit i is 0 and flag i has been read as 1 since the last zero write to that bit. Every zero write to the bit uses up that read. A one written to a bit leaves both the flag and the earlier read unchanged.
- R8: When a set event and a valid clear fall on the same cycle, the flag stays 1.
- R9: With buffering on and the partner in compare mode, a match on register 0 (or 1) loads it from register 2 (or 3) at the end of the pulse cycle. The buffer keeps its value.
- R10: With buffering on and the partner in capture mode, a capture on register 0 (or 1) moves that register's previous value into register 2 (or 3).
- R11: A register that is acting as a buffer produces no match pulse and no flag, and it ignores its own capture strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby_req | input | 1 | Synchronous counter clear |
| cnt_en | input | 1 | Count enable, one step per cycle |
| bus_sel | input | 1 | Bus access select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (wins over read) |
| bus_size16 | input | 1 | 1 = word access, 0 = byte access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| bus_err | output | 1 | Wrong-size access indication |
| cap_strobe | input | 4 | Capture strobes, one per general register |
| match_pulse | output | 4 | Compare match pulses, one per general register |

## Verification
The assertions check several rules on every cycle:

- The counter clear on standby.
- A byte write leaving the counter intact.
- Every flag rising only after a match or capture.
- Every flag falling only when a read as one came before it.
- Capture copying the counter.
- Buffered capture shifting the old value out.

Only the bench scenarios can show the cycle in which a match pulse appears. The same holds for these behaviours:

- Buffered compare reload.
- A buffer register staying silent.
- The set-over-clear collision.
- The full read, write and re-read sequence of the flag handshake.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

    // Kind of bus access seen in the current cycle
    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_RD,
        ACC_WR,
        ACC_BAD
    } acc_e;

    localparam int unsigned CNT_ADDR = 0;

endpackage

// File: rtl/cc_counter.sv
module cc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         tick_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tick;   // counter changed by counting on the last edge
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (ld_i) begin
            st_d.cnt = ld_val_i;
        end else if (inc_i) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign tick_o = st_q.tick;

endmodule

// File: rtl/cc_gr_bank.sv
module cc_gr_bank #(
    parameter int W    = 16,
    parameter int NREG = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [W-1:0]            cnt_i,
    input  logic                    tick_i,
    input  logic [NREG-1:0]         cap_mode_i,
    input  logic [NREG/2-1:0]       buf_en_i,
    input  logic [NREG-1:0]         cap_strobe_i,
    input  logic [NREG-1:0]         wr_en_i,
    input  logic [W-1:0]            wr_data_i,
    output logic [NREG-1:0][W-1:0]  gr_o,
    output logic [NREG-1:0]         match_o,
    output logic [NREG-1:0]         set_o
);

    localparam int NBUF = NREG / 2;

    logic [NREG-1:0][W-1:0] gr_d, gr_q;
    logic [NREG-1:0]        slot_dis;
    logic [NREG-1:0]        capt;

    // Upper half of the bank is silenced while it serves as a buffer
    for (genvar g = 0; g < NREG; g++) begin : g_dis
        if (g >= NBUF) begin : g_upper
            assign slot_dis[g] = buf_en_i[g-NBUF];
        end else begin : g_lower
            assign slot_dis[g] = 1'b0;
        end
    end

    always_comb begin
        gr_d    = gr_q;
        match_o = '0;
        capt    = '0;
        for (int i = 0; i < NREG; i++) begin
            match_o[i] = tick_i && (cnt_i == gr_q[i]) && !cap_mode_i[i] && !slot_dis[i];
            capt[i]    = cap_strobe_i[i] && cap_mode_i[i] && !slot_dis[i];
            if (wr_en_i[i]) begin
                gr_d[i] = wr_data_i;
            end
            if (capt[i]) begin
                gr_d[i] = cnt_i;
            end
        end
        // Buffer transfers override any bus write on the same edge
        for (int i = 0; i < NBUF; i++) begin
            if (buf_en_i[i]) begin
                if (capt[i]) begin
                    gr_d[i+NBUF] = gr_q[i];
                end else if (match_o[i]) begin
                    gr_d[i] = gr_q[i+NBUF];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gr_q <= '1;
        end else begin
            gr_q <= gr_d;
        end
    end

    assign gr_o  = gr_q;
    assign set_o = match_o | capt;

endmodule

// File: rtl/cc_flag_unit.sv
module cc_flag_unit #(
    parameter int NREG = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] set_i,
    input  logic            rd_stat_i,
    input  logic            wr_stat_i,
    input  logic [NREG-1:0] wdata_i,
    output logic [NREG-1:0] flags_o,
    output logic [NREG-1:0] seen_o
);

    typedef struct packed {
        logic [NREG-1:0] flag;
        logic [NREG-1:0] seen;   // flag was read as one, clear is armed
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (rd_stat_i && st_q.flag[i]) begin
                st_d.seen[i] = 1'b1;
            end
            if (wr_stat_i && !wdata_i[i]) begin
                if (st_q.seen[i]) begin
                    st_d.flag[i] = 1'b0;
                end
                st_d.seen[i] = 1'b0;
            end
            if (set_i[i]) begin
                st_d.flag[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flag;
    assign seen_o  = st_q.seen;

endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
    import cc_timer_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 4,
    parameter int AW   = $clog2(NREG + 3)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            standby_req,
    input  logic            cnt_en,
    input  logic            bus_sel,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic            bus_size16,
    input  logic [AW-1:0]   bus_addr,
    input  logic [W-1:0]    bus_wdata,
    output logic [W-1:0]    bus_rdata,
    output logic            bus_err,
    input  logic [NREG-1:0] cap_strobe,
    output logic [NREG-1:0] match_pulse
);

    localparam int NBUF   = NREG / 2;
    localparam int CW     = NREG + NBUF;
    localparam int STAT_A = NREG + 1;
    localparam int CTRL_A = NREG + 2;

    typedef struct packed {
        logic [CW-1:0] ctrl;
    } top_st_t;

    top_st_t st_d, st_q;

    acc_e                   acc;
    logic                   cnt_ld;
    logic [NREG-1:0]        gr_wr;
    logic                   stat_rd;
    logic                   stat_wr;
    logic [W-1:0]           cnt_q;
    logic                   tick_q;
    logic [NREG-1:0][W-1:0] gr_q;
    logic [NREG-1:0]        gr_match;
    logic [NREG-1:0]        gr_set;
    logic [NREG-1:0]        flags_q;
    logic [NREG-1:0]        seen_q;
    logic [NREG-1:0]        cap_mode;
    logic [NBUF-1:0]        buf_en;

    assign cap_mode = st_q.ctrl[NREG-1:0];
    assign buf_en   = st_q.ctrl[CW-1:NREG];

    always_comb begin
        st_d      = st_q;
        acc       = ACC_IDLE;
        cnt_ld    = 1'b0;
        gr_wr     = '0;
        stat_rd   = 1'b0;
        stat_wr   = 1'b0;
        bus_rdata = '0;

        if (bus_sel && (bus_rd || bus_wr)) begin
            if (!bus_size16 && (bus_addr <= AW'(NREG))) begin
                acc = ACC_BAD;
            end else if (bus_wr) begin
                acc = ACC_WR;
            end else begin
                acc = ACC_RD;
            end
        end

        if (acc == ACC_WR) begin
            cnt_ld  = (bus_addr == AW'(CNT_ADDR));
            stat_wr = (bus_addr == AW'(STAT_A));
            for (int i = 0; i < NREG; i++) begin
                gr_wr[i] = (bus_addr == AW'(i + 1));
            end
            if (bus_addr == AW'(CTRL_A)) begin
                st_d.ctrl = bus_wdata[CW-1:0];
            end
        end

        if (acc == ACC_RD) begin
            stat_rd = (bus_addr == AW'(STAT_A));
            if (bus_addr == AW'(CNT_ADDR)) begin
                bus_rdata = cnt_q;
            end
            for (int i = 0; i < NREG; i++) begin
                if (bus_addr == AW'(i + 1)) begin
                    bus_rdata = gr_q[i];
                end
            end
            if (bus_addr == AW'(STAT_A)) begin
                bus_rdata = {{(W-NREG){1'b0}}, flags_q};
            end
            if (bus_addr == AW'(CTRL_A)) begin
                bus_rdata = {{(W-CW){1'b0}}, st_q.ctrl};
            end
        end

        bus_err = (acc == ACC_BAD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cc_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (standby_req),
        .ld_i     (cnt_ld),
        .ld_val_i (bus_wdata),
        .inc_i    (cnt_en),
        .cnt_o    (cnt_q),
        .tick_o   (tick_q)
    );

    cc_gr_bank #(.W(W), .NREG(NREG)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_i        (cnt_q),
        .tick_i       (tick_q),
        .cap_mode_i   (cap_mode),
        .buf_en_i     (buf_en),
        .cap_strobe_i (cap_strobe),
        .wr_en_i      (gr_wr),
        .wr_data_i    (bus_wdata),
        .gr_o         (gr_q),
        .match_o      (gr_match),
        .set_o        (gr_set)
    );

    cc_flag_unit #(.NREG(NREG)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (gr_set),
        .rd_stat_i (stat_rd),
        .wr_stat_i (stat_wr),
        .wdata_i   (bus_wdata[NREG-1:0]),
        .flags_o   (flags_q),
        .seen_o    (seen_q)
    );

    assign match_pulse = gr_match;

endmodule

// File: rtl/cc_timer_chan_chk.sv
module cc_timer_chan_chk #(
    parameter int W      = 16,
    parameter int NREG   = 4,
    parameter int AW     = 3,
    parameter int STAT_A = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   standby_req,
    input logic                   cnt_en,
    input logic                   bus_sel,
    input logic                   bus_wr,
    input logic                   bus_size16,
    input logic [AW-1:0]          bus_addr,
    input logic [NREG-1:0]        wdata_lo,
    input logic [NREG-1:0]        cap_strobe,
    input logic [NREG-1:0]        match_pulse,
    input logic [W-1:0]           cnt_q,
    input logic [NREG-1:0][W-1:0] gr_q,
    input logic [NREG-1:0]        flags_q,
    input logic [NREG-1:0]        seen_q,
    input logic [NREG-1:0]        cap_mode,
    input logic [NREG/2-1:0]      buf_en
);

    localparam int NBUF = NREG / 2;

    // R3: standby clears the counter on the next edge
    assert_standby_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        standby_req |=> (cnt_q == '0));

    // R4: a byte write to the counter leaves it untouched
    assert_byte_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_size16 && bus_addr == '0 && !standby_req && !cnt_en)
        |=> $stable(cnt_q));

    for (genvar g = 0; g < NREG; g++) begin : g_flag
        // R5, R8: a match pulse always leaves its flag set
        assert_pulse_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            match_pulse[g] |=> flags_q[g]);

        // R6: a flag only rises after a match or a strobe
        assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_q[g]) |-> $past(match_pulse[g] || cap_strobe[g]));

        // R7: a flag only falls after it was seen as one
        assert_fall_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags_q[g]) |-> $past(seen_q[g]));

        // R7: writing one to a set flag keeps it set
        assert_one_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && bus_addr == AW'(STAT_A) && wdata_lo[g] && flags_q[g])
            |=> flags_q[g]);
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_low
        // R6: a capture loads the counter value of the strobe cycle
        assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_strobe[g] && cap_mode[g]) |=> (gr_q[g] == $past(cnt_q)));

        // R10: buffered capture shifts the previous value into the buffer
        assert_buf_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_strobe[g] && cap_mode[g] && buf_en[g]) |=> (gr_q[g+NBUF] == $past(gr_q[g])));
    end

endmodule

bind cc_timer_chan cc_timer_chan_chk #(
    .W(W), .NREG(NREG), .AW(AW), .STAT_A(NREG + 1)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby_req (standby_req),
    .cnt_en      (cnt_en),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_size16  (bus_size16),
    .bus_addr    (bus_addr),
    .wdata_lo    (bus_wdata[NREG-1:0]),
    .cap_strobe  (cap_strobe),
    .match_pulse (match_pulse),
    .cnt_q       (cnt_q),
    .gr_q        (gr_q),
    .flags_q     (flags_q),
    .seen_q      (seen_q),
    .cap_mode    (cap_mode),
    .buf_en      (buf_en)
);

// File: tb/cc_timer_chan_tb.sv
module cc_timer_chan_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_req = 1'b0;
    logic        cnt_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_size16 = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  cap_strobe = '0;
    logic [3:0]  match_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] val;
        logic        err;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t item;

    cc_timer_chan u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_req (standby_req),
        .cnt_en      (cnt_en),
        .bus_sel     (bus_sel),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_size16  (bus_size16),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_err     (bus_err),
        .cap_strobe  (cap_strobe),
        .match_pulse (match_pulse)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares each read against the scoreboard queue
    always begin
        @(negedge clk);
        #2;
        if (bus_sel && bus_rd && !bus_wr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard-empty", bus_rdata, 16'h0);
            end else begin
                item = exp_q.pop_front();
                chk(bus_rdata === item.val && bus_err === item.err, item.tag,
                    {bus_err, bus_rdata[14:0]}, {item.err, item.val[14:0]});
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size16 = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag, input bit sz = 1'b1);
        exp_t it;
        it.val = e; it.err = !sz && (a <= 3'd4); it.tag = tag;
        exp_q.push_back(it);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a; bus_size16 = sz;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0; bus_size16 = 1'b1;
    endtask

    task automatic tick(input int n);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic strobe(input logic [3:0] m);
        cap_strobe = m;
        @(negedge clk);
        cap_strobe = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, 16'h0000, "R1 counter reset");
        rd(3'd1, 16'hFFFF, "R1 reg0 reset");
        rd(3'd4, 16'hFFFF, "R1 reg3 reset");
        rd(3'd5, 16'h0000, "R1 status reset");
        rd(3'd6, 16'h0000, "R1 mode reset");

        wr(3'd1, 16'h0010); wr(3'd2, 16'h0020); wr(3'd3, 16'h0030); wr(3'd4, 16'h0040);
        rd(3'd1, 16'h0010, "R1 reg0 write");

        // R2 counting and wrap
        tick(5);
        rd(3'd0, 16'h0005, "R2 count");
        wr(3'd0, 16'hFFFE);
        tick(2);
        rd(3'd0, 16'h0000, "R2 wrap");

        // R4 byte accesses
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 16'h1234; bus_size16 = 1'b0;
        #2 chk(bus_err === 1'b1, "R4 byte write err", {15'h0, bus_err}, 16'h1);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_size16 = 1'b1;
        rd(3'd1, 16'h0010, "R4 byte write ignored");
        rd(3'd0, 16'h0000, "R4 byte read", 1'b0);

        // R3 write priority and standby
        wr(3'd0, 16'h000E);
        tick(2);
        #2 chk(match_pulse === 4'b0001, "R5 pulse", {12'h0, match_pulse}, 16'h1);
        @(negedge clk);
        #2 chk(match_pulse === 4'b0000, "R5 pulse single", {12'h0, match_pulse}, 16'h0);
        @(negedge clk);
        rd(3'd5, 16'h0001, "R5 flag set");
        cnt_en = 1'b1;
        wr(3'd0, 16'h0100);
        cnt_en = 1'b0;
        rd(3'd0, 16'h0100, "R3 write over count");
        cnt_en = 1'b1; standby_req = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0777;
        @(negedge clk);
        cnt_en = 1'b0; standby_req = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(3'd0, 16'h0000, "R3 standby");

        // R7 handshake (flag 0 was read as one above)
        wr(3'd5, 16'h000F);
        rd(3'd5, 16'h0001, "R7 write one no effect");
        wr(3'd5, 16'h0000);
        rd(3'd5, 16'h0000, "R7 clear after read");

        wr(3'd0, 16'h001F);
        tick(1);
        @(negedge clk);
        wr(3'd5, 16'h0000);
        rd(3'd5, 16'h0002, "R7 clear without read");
        wr(3'd0, 16'h001F);
        tick(1);
        wr(3'd5, 16'h0000);
        rd(3'd5, 16'h0002, "R8 set wins");
        wr(3'd5, 16'h0000);
        rd(3'd5, 16'h0000, "R7 clear after second read");

        // R6 capture
        wr(3'd6, 16'h0001);
        wr(3'd0, 16'h0123);
        strobe(4'b0001);
        rd(3'd1, 16'h0123, "R6 capture value");
        rd(3'd5, 16'h0001, "R6 capture flag");
        strobe(4'b0010);
        rd(3'd2, 16'h0020, "R6 strobe ignored in compare");
        rd(3'd5, 16'h0001, "R6 no flag in compare");
        wr(3'd5, 16'h0000);
        rd(3'd5, 16'h0000, "R7 clear capture flag");

        // R10 buffered capture, R11 buffer strobe ignored
        wr(3'd6, 16'h0011);
        wr(3'd0, 16'h0200);
        strobe(4'b0001);
        rd(3'd1, 16'h0200, "R10 partner captured");
        rd(3'd3, 16'h0123, "R10 old value shifted");
        strobe(4'b0100);
        rd(3'd3, 16'h0123, "R11 buffer strobe ignored");
        rd(3'd5, 16'h0001, "R11 no buffer flag");
        wr(3'd5, 16'h0000);

        // R9 buffered compare, R11 buffer compare silent
        wr(3'd6, 16'h0020);
        wr(3'd4, 16'h0050);
        wr(3'd0, 16'h001F);
        tick(1);
        #2 chk(match_pulse === 4'b0010, "R9 partner pulse", {12'h0, match_pulse}, 16'h2);
        @(negedge clk);
        rd(3'd2, 16'h0050, "R9 reload from buffer");
        rd(3'd4, 16'h0050, "R9 buffer kept");
        wr(3'd0, 16'h004F);
        tick(1);
        #2 chk(match_pulse === 4'b0010, "R11 buffer no pulse", {12'h0, match_pulse}, 16'h2);
        @(negedge clk);
        rd(3'd5, 16'h0002, "R11 buffer no flag");

        @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard-drain", 16'(exp_q.size()), 16'h0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all) act=timeout exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule